// File: doc/BRIEF.md
# Ethernet Transmit Header Generator

This block turns payload packets from on-chip producers into complete outgoing Ethernet frames. Each packet is announced by a descriptor carrying a port number and a payload length, and then arrives one byte per beat. The port number selects an entry in a small lookup table. The entry holds the destination MAC, the type/length field, a destination IP address, a destination UDP port and two mode flags. One flag adds an IPv4 and UDP header. The other adds a one-word VITA-49 signal-data prefix. The source MAC, source IP and source UDP port come from configuration inputs that are shared by all ports.

The frame leaves on a byte stream with ready/valid flow control. It is the header followed by the payload, unchanged and with no frame check sequence. Each frame is meant for its own fixed-size slot of the transmit buffer. When the last byte has been accepted, a command is queued. The command holds the slot's byte pointer and the frame size. The interrupt stays high while any command is waiting. A full command queue stops new descriptors. A frame larger than the standard maximum is consumed and discarded.

Top module: `eth_tx_hdr_gen`

## Requirements
- R1: The frame begins with the destination MAC from the selected port's table entry, then the source MAC from the configuration input, then the entry's 16-bit type/length field. All multi-byte fields are sent most significant byte first.
- R2: When the entry's IP flag is set, a 20-byte IPv4 header follows the type field. Its bytes are 45 00, the total length, id 0000, flags 4000, TTL 40, protocol 11, the header checksum, the source IP and the destination IP. An 8-byte UDP header follows it: source port, destination port, UDP length and checksum 0000. The UDP length is 8 plus the prefix bytes plus the payload. The total length is 20 plus the UDP length.
- R3: When the entry's VITA flag is set, a 32-bit word comes directly before the payload. Bits 31:28 are 1, bits 27:20 are 0, bits 19:16 hold the VITA frame count and bits 15:0 hold 1 + ceil(payload/4).
- R4: The payload bytes follow the header unchanged. out_last marks the final payload byte, and no check sequence is appended. The header bytes hold steady while out_ready is low.
- R5: Each emitted frame produces a command. Its pointer is slot × 2048, and its size is the header bytes plus the payload bytes. The slot starts at 0, advances by one per emitted frame and wraps after 8.
- R6: irq is high exactly while commands are queued. cmd_ptr and cmd_size show the oldest command, and a cmd_pop pulse removes it. Order is first in, first out, with a depth of 4.
- R7: While 4 commands are queued, desc_ready is low and no new frame starts. One pop re-opens it.
- R8: A packet whose frame would exceed 1514 bytes has its payload accepted and discarded. It produces no output, no command, no slot advance and no count advance. A frame of exactly 1514 bytes is sent.
- R9: The VITA frame count starts at 0 and increases by one, modulo 16, after each emitted frame whose port has the VITA flag.
- R10: After reset, out_valid and irq are low and desc_ready is high. Descriptors carry a payload length of at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_smac | input | 48 | Source MAC |
| cfg_sip | input | 32 | Source IPv4 address |
| cfg_sport | input | 16 | Source UDP port |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 4 | Table entry index |
| tbl_dmac | input | 48 | Destination MAC to store |
| tbl_etype | input | 16 | Type/length field to store |
| tbl_dip | input | 32 | Destination IPv4 address to store |
| tbl_dport | input | 16 | Destination UDP port to store |
| tbl_ip | input | 1 | IP/UDP header flag to store |
| tbl_vita | input | 1 | VITA prefix flag to store |
| desc_valid | input | 1 | Packet descriptor valid |
| desc_ready | output | 1 | Descriptor accepted |
| desc_port | input | 4 | Port number of the packet |
| desc_len | input | 11 | Payload length in bytes |
| pay_valid | input | 1 | Payload byte valid |
| pay_ready | output | 1 | Payload byte accepted |
| pay_data | input | 8 | Payload byte |
| out_valid | output | 1 | Frame byte valid |
| out_ready | input | 1 | Frame byte accepted downstream |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |
| cmd_pop | input | 1 | Remove the oldest command |
| cmd_ptr | output | 16 | Slot byte pointer of the oldest command |
| cmd_size | output | 14 | Frame size of the oldest command |
| irq | output | 1 | Commands pending |

## Verification
The hardest conditions to reach are the discard path and its size boundary, and the back-pressure that comes from the command queue. To get there, the stimulus sends two packets on a port that has both header options enabled. Their payload lengths put the frame one byte over and exactly at the 1514-byte limit. It then checks that the oversized one leaves the slot pointer and the VITA count untouched. To fill the queue, four frames are sent without any pops, and desc_ready is watched until one pop releases it. While this happens, the output ready line follows an irregular pattern, so the held-header and gapped-payload paths are exercised too.

// File: rtl/ethtx_pkg.sv
package ethtx_pkg;
  localparam int HDR_MAX = 46;
  localparam int FLEN_W  = 14;

  typedef struct packed {
    logic [47:0] dmac;
    logic [15:0] etype;
    logic [31:0] dip;
    logic [15:0] dport;
    logic        ip_en;
    logic        vita_en;
  } port_ent_t;

  typedef struct packed {
    logic [15:0]       ptr;
    logic [FLEN_W-1:0] size;
  } tx_cmd_t;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PAY, S_DROP} tx_st_e;

  function automatic logic [5:0] hdr_bytes(input logic ip, input logic vt);
    return 6'd14 + (ip ? 6'd28 : 6'd0) + (vt ? 6'd4 : 6'd0);
  endfunction
endpackage

// File: rtl/ethtx_port_table.sv
module ethtx_port_table
  import ethtx_pkg::*;
#(
  parameter int NPORT = 16,
  localparam int PW = $clog2(NPORT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [PW-1:0]   widx,
  input  port_ent_t       wdata,
  input  logic [PW-1:0]   ridx,
  output port_ent_t       rdata
);
  port_ent_t ent_q [NPORT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPORT; i++) ent_q[i] <= '0;
    end else if (we) begin
      ent_q[widx] <= wdata;
    end
  end

  assign rdata = ent_q[ridx];
endmodule

// File: rtl/ethtx_hdr_build.sv
module ethtx_hdr_build
  import ethtx_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  port_ent_t              ent,
  input  logic [47:0]            smac,
  input  logic [31:0]            sip,
  input  logic [15:0]            sport,
  input  logic [LEN_W-1:0]       plen,
  input  logic [3:0]             vcnt,
  output logic [HDR_MAX*8-1:0]   hvec,
  output logic [5:0]             hlen
);
  logic [15:0]  vwords, ulen, tlen, csum;
  logic [19:0]  sum;
  logic [16:0]  f1, f2;
  logic [111:0] eth;
  logic [159:0] iph;
  logic [63:0]  udp;
  logic [31:0]  vw;

  always_comb begin
    vwords = 16'd1 + ((16'(plen) + 16'd3) >> 2);
    ulen   = 16'd8 + (ent.vita_en ? 16'd4 : 16'd0) + 16'(plen);
    tlen   = 16'd20 + ulen;
    sum    = 20'h04500 + 20'(tlen) + 20'h04000 + 20'h04011
           + 20'(sip[31:16]) + 20'(sip[15:0])
           + 20'(ent.dip[31:16]) + 20'(ent.dip[15:0]);
    f1     = 17'(sum[15:0]) + 17'(sum[19:16]);
    f2     = 17'(f1[15:0]) + 17'(f1[16]);
    csum   = ~f2[15:0];
    eth    = {ent.dmac, smac, ent.etype};
    iph    = {8'h45, 8'h00, tlen, 16'h0000, 16'h4000, 8'h40, 8'h11, csum, sip, ent.dip};
    udp    = {sport, ent.dport, ulen, 16'h0000};
    vw     = {4'h1, 8'h00, vcnt, vwords};
    case ({ent.ip_en, ent.vita_en})
      2'b00:   hvec = {eth, 256'b0};
      2'b01:   hvec = {eth, vw, 224'b0};
      2'b10:   hvec = {eth, iph, udp, 32'b0};
      default: hvec = {eth, iph, udp, vw};
    endcase
    hlen = hdr_bytes(ent.ip_en, ent.vita_en);
  end
endmodule

// File: rtl/ethtx_cmd_fifo.sv
module ethtx_cmd_fifo
  import ethtx_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  tx_cmd_t wdata,
  input  logic    pop,
  output tx_cmd_t rdata,
  output logic    full,
  output logic    nempty
);
  tx_cmd_t     mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_pop;

  always_comb begin
    do_pop = pop && (cnt_q != '0);
    wp_d   = push ? AW'(32'(wp_q) + 1) : wp_q;
    rp_d   = do_pop ? AW'(32'(rp_q) + 1) : rp_q;
    cnt_d  = cnt_q + (push ? 1'b1 : 1'b0) - (do_pop ? 1'b1 : 1'b0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= wdata;
  end

  assign rdata  = mem_q[rp_q];
  assign full   = (cnt_q == (AW+1)'(DEPTH));
  assign nempty = (cnt_q != '0);

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r6_pop_empty_safe: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !nempty && !push) |=> !nempty);
  a_r6_last_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt_q == (AW+1)'(1) && !push) |=> !nempty);
endmodule

// File: rtl/eth_tx_hdr_gen.sv
module eth_tx_hdr_gen
  import ethtx_pkg::*;
#(
  parameter int NPORT      = 16,
  parameter int CMD_DEPTH  = 4,
  parameter int NSLOT      = 8,
  parameter int SLOT_BYTES = 2048,
  parameter int MAX_FRAME  = 1514,
  parameter int LEN_W      = 11,
  localparam int PW = $clog2(NPORT),
  localparam int SW = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [47:0]       cfg_smac,
  input  logic [31:0]       cfg_sip,
  input  logic [15:0]       cfg_sport,
  input  logic              tbl_we,
  input  logic [PW-1:0]     tbl_idx,
  input  logic [47:0]       tbl_dmac,
  input  logic [15:0]       tbl_etype,
  input  logic [31:0]       tbl_dip,
  input  logic [15:0]       tbl_dport,
  input  logic              tbl_ip,
  input  logic              tbl_vita,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [PW-1:0]     desc_port,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [7:0]        pay_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  input  logic              cmd_pop,
  output logic [15:0]       cmd_ptr,
  output logic [FLEN_W-1:0] cmd_size,
  output logic              irq
);
  logic [1:0] rsync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  tx_st_e            st_q, st_d;
  logic [5:0]        idx_q, idx_d;
  logic [LEN_W-1:0]  rem_q, rem_d, plen_q, plen_d;
  port_ent_t         ent_q, ent_d, tbl_rd;
  logic [FLEN_W-1:0] flen_q, flen_d, acc_len;
  logic [SW-1:0]     slot_q, slot_d;
  logic [3:0]        vcnt_q, vcnt_d;
  logic              push, full, oversize;
  logic [HDR_MAX*8-1:0] hvec;
  logic [5:0]        hlen;
  logic [7:0]        hbyte;
  tx_cmd_t           cmd_w, cmd_r;

  ethtx_port_table #(.NPORT(NPORT)) u_tbl (
    .clk(clk), .rst_n(rst_q_n), .we(tbl_we), .widx(tbl_idx),
    .wdata('{dmac: tbl_dmac, etype: tbl_etype, dip: tbl_dip, dport: tbl_dport,
             ip_en: tbl_ip, vita_en: tbl_vita}),
    .ridx(desc_port), .rdata(tbl_rd));

  ethtx_hdr_build #(.LEN_W(LEN_W)) u_hdr (
    .ent(ent_q), .smac(cfg_smac), .sip(cfg_sip), .sport(cfg_sport),
    .plen(plen_q), .vcnt(vcnt_q), .hvec(hvec), .hlen(hlen));

  assign cmd_w = '{ptr: 16'(32'(slot_q) * SLOT_BYTES), size: flen_q};

  ethtx_cmd_fifo #(.DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_q_n), .push(push), .wdata(cmd_w), .pop(cmd_pop),
    .rdata(cmd_r), .full(full), .nempty(irq));

  assign cmd_ptr  = cmd_r.ptr;
  assign cmd_size = cmd_r.size;

  always_comb begin
    acc_len  = FLEN_W'(desc_len) + FLEN_W'(hdr_bytes(tbl_rd.ip_en, tbl_rd.vita_en));
    oversize = acc_len > FLEN_W'(MAX_FRAME);
    hbyte    = hvec[8*(HDR_MAX-1-int'(idx_q)) +: 8];
  end

  always_comb begin
    st_d = st_q; idx_d = idx_q; rem_d = rem_q; plen_d = plen_q; ent_d = ent_q;
    flen_d = flen_q; slot_d = slot_q; vcnt_d = vcnt_q;
    desc_ready = 1'b0; pay_ready = 1'b0; out_valid = 1'b0; out_data = 8'h00;
    out_last = 1'b0; push = 1'b0;
    case (st_q)
      S_IDLE: begin
        desc_ready = !full;
        if (desc_valid && !full) begin
          ent_d  = tbl_rd;
          rem_d  = desc_len;
          plen_d = desc_len;
          flen_d = acc_len;
          idx_d  = '0;
          st_d   = oversize ? S_DROP : S_HDR;
        end
      end
      S_HDR: begin
        out_valid = 1'b1;
        out_data  = hbyte;
        if (out_ready) begin
          if (idx_q == hlen - 6'd1) st_d = S_PAY;
          else                      idx_d = idx_q + 6'd1;
        end
      end
      S_PAY: begin
        out_valid = pay_valid;
        out_data  = pay_data;
        out_last  = (rem_q == LEN_W'(1));
        pay_ready = out_ready;
        if (pay_valid && out_ready) begin
          rem_d = rem_q - LEN_W'(1);
          if (rem_q == LEN_W'(1)) begin
            push   = 1'b1;
            st_d   = S_IDLE;
            slot_d = slot_q + SW'(1);
            if (ent_q.vita_en) vcnt_d = vcnt_q + 4'd1;
          end
        end
      end
      default: begin
        pay_ready = 1'b1;
        if (pay_valid) begin
          rem_d = rem_q - LEN_W'(1);
          if (rem_q == LEN_W'(1)) st_d = S_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q <= S_IDLE; idx_q <= '0; rem_q <= '0; plen_q <= '0; ent_q <= '0;
      flen_q <= '0; slot_q <= '0; vcnt_q <= '0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; rem_q <= rem_d; plen_q <= plen_d; ent_q <= ent_d;
      flen_q <= flen_d; slot_q <= slot_d; vcnt_q <= vcnt_d;
    end
  end

  a_r4_hdr_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    (st_q == S_HDR && !out_ready) |=> (out_valid && out_data == $past(out_data)));
  a_r8_size_cap: assert property (@(posedge clk) disable iff (!rst_q_n)
    push |-> (flen_q <= FLEN_W'(MAX_FRAME)));
  a_r4_last_ends: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && out_ready && out_last) |=> (st_q == S_IDLE && irq));
  a_r8_drop_silent: assert property (@(posedge clk) disable iff (!rst_q_n)
    (st_q == S_DROP) |-> (!out_valid && !push));
endmodule

// File: tb/sim_eth_tx_hdr_gen.sv
module sim_eth_tx_hdr_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [47:0] cfg_smac = 48'h02_11_22_33_44_55;
  logic [31:0] cfg_sip  = 32'hC0A8_0001;
  logic [15:0] cfg_sport = 16'd1001;
  logic tbl_we = 0, tbl_ip = 0, tbl_vita = 0;
  logic [3:0] tbl_idx = 0, desc_port = 0;
  logic [47:0] tbl_dmac = 0;
  logic [15:0] tbl_etype = 0, tbl_dport = 0;
  logic [31:0] tbl_dip = 0;
  logic desc_valid = 0, pay_valid = 0, out_ready = 0, cmd_pop = 0;
  logic [10:0] desc_len = 0;
  logic [7:0] pay_data = 0;
  logic desc_ready, pay_ready, out_valid, out_last, irq;
  logic [7:0] out_data;
  logic [15:0] cmd_ptr;
  logic [13:0] cmd_size;

  eth_tx_hdr_gen u0 (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [8:0]  exp_q [$];
  logic [29:0] cmd_q [$];
  int exp_slot = 0, exp_vcnt = 0;
  logic [47:0] b_dmac [4];
  logic [15:0] b_et [4], b_dport [4];
  logic [31:0] b_dip [4];
  bit b_ip [4], b_v [4];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready <= (cyc % 7 != 3) && (cyc % 11 != 5);
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected byte: actual %02h expected none", out_data);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        if ({out_last, out_data} !== e) begin
          errors++;
          $display("FAIL R1/R2/R3/R4 frame byte: actual %03h expected %03h", {out_last, out_data}, e);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic twr(input int p, input logic [47:0] m, input logic [15:0] et,
                     input logic [31:0] dip, input logic [15:0] dp, input bit ip, input bit v);
    b_dmac[p] = m; b_et[p] = et; b_dip[p] = dip; b_dport[p] = dp; b_ip[p] = ip; b_v[p] = v;
    @(posedge clk); #1;
    tbl_we = 1; tbl_idx = 4'(p); tbl_dmac = m; tbl_etype = et; tbl_dip = dip;
    tbl_dport = dp; tbl_ip = ip; tbl_vita = v;
    @(posedge clk); #1 tbl_we = 0;
  endtask

  function automatic void pb(input logic [7:0] b);
    exp_q.push_back({1'b0, b});
  endfunction
  function automatic void p16(input logic [15:0] w);
    pb(w[15:8]); pb(w[7:0]);
  endfunction
  function automatic logic [7:0] pval(input int seed, input int i);
    return 8'((seed + i * 7) & 255);
  endfunction

  task automatic send(input int p, input int len, input int seed);
    int hl, ul, tl, s;
    hl = 14 + (b_ip[p] ? 28 : 0) + (b_v[p] ? 4 : 0);
    if (hl + len <= 1514) begin
      for (int k = 0; k < 6; k++) pb(b_dmac[p][47-8*k -: 8]);
      for (int k = 0; k < 6; k++) pb(cfg_smac[47-8*k -: 8]);
      p16(b_et[p]);
      if (b_ip[p]) begin
        ul = 8 + (b_v[p] ? 4 : 0) + len;
        tl = 20 + ul;
        s = 'h4500 + tl + 'h4000 + 'h4011 + cfg_sip[31:16] + cfg_sip[15:0]
          + b_dip[p][31:16] + b_dip[p][15:0];
        while (s > 'hFFFF) s = (s & 'hFFFF) + (s >> 16);
        p16(16'h4500); p16(16'(tl)); p16(16'h0); p16(16'h4000); p16(16'h4011);
        p16(~16'(s)); p16(cfg_sip[31:16]); p16(cfg_sip[15:0]);
        p16(b_dip[p][31:16]); p16(b_dip[p][15:0]);
        p16(cfg_sport); p16(b_dport[p]); p16(16'(ul)); p16(16'h0);
      end
      if (b_v[p]) begin
        p16({4'h1, 8'h00, 4'(exp_vcnt)});
        p16(16'(1 + (len + 3) / 4));
        exp_vcnt = (exp_vcnt + 1) % 16;
      end
      for (int i = 0; i < len; i++) exp_q.push_back({(i == len - 1), pval(seed, i)});
      cmd_q.push_back({16'(exp_slot * 2048), 14'(hl + len)});
      exp_slot = (exp_slot + 1) % 8;
    end
    @(posedge clk); #1;
    desc_valid = 1; desc_port = 4'(p); desc_len = 11'(len);
    do @(negedge clk); while (!desc_ready);
    @(posedge clk); #1 desc_valid = 0;
    for (int i = 0; i < len; i++) begin
      pay_valid = 1; pay_data = pval(seed, i);
      do @(negedge clk); while (!pay_ready);
      @(posedge clk); #1;
    end
    pay_valid = 0;
    while (exp_q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic pop_chk();
    logic [29:0] e;
    @(negedge clk);
    chk("R6 irq pending", 32'(irq), 1);
    e = cmd_q.pop_front();
    chk("R5 cmd_ptr", 32'(cmd_ptr), 32'(e[29:14]));
    chk("R5 cmd_size", 32'(cmd_size), 32'(e[13:0]));
    @(posedge clk); #1 cmd_pop = 1;
    @(posedge clk); #1 cmd_pop = 0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 out_valid at reset", 32'(out_valid), 0);
    chk("R10 irq at reset", 32'(irq), 0);
    chk("R10 desc_ready at reset", 32'(desc_ready), 1);

    twr(0, 48'hAABBCCDDEEF0, 16'h88B5, 32'h0, 16'h0, 0, 0);
    twr(1, 48'h010203040506, 16'h0800, 32'h0A000005, 16'd1000, 1, 0);
    twr(2, 48'hFFFFFFFFFFFF, 16'h1234, 32'h0, 16'h0, 0, 1);
    twr(3, 48'h0A0B0C0D0E0F, 16'h0800, 32'hC0A80164, 16'd4991, 1, 1);

    send(0, 10, 3);     // R1 plain MAC header
    send(1, 37, 40);    // R2 IPv4 + UDP
    send(2, 5, 9);      // R3 VITA word, rounded word count
    send(3, 64, 100);   // R2 R3 both
    @(negedge clk);
    chk("R6 irq with 4 queued", 32'(irq), 1);
    for (int k = 0; k < 4; k++) pop_chk();
    @(negedge clk);
    chk("R6 irq cleared after pops", 32'(irq), 0);

    send(3, 1469, 7);   // R8 1515 bytes: dropped
    @(negedge clk);
    chk("R8 no command after drop", 32'(irq), 0);
    send(3, 1468, 8);   // R8 exactly 1514: sent, slot and R9 count unchanged by drop
    pop_chk();

    for (int k = 0; k < 4; k++) send(2, 8 + k, 20 + k);  // R9 count steps, R5 slot wraps
    @(negedge clk);
    chk("R7 desc_ready low when queue full", 32'(desc_ready), 0);
    pop_chk();
    @(negedge clk);
    chk("R7 desc_ready back after pop", 32'(desc_ready), 1);
    for (int k = 0; k < 3; k++) pop_chk();
    send(0, 1, 55);     // R4 single-byte payload
    pop_chk();

    done = 1;
    summary();
    $finish;
  end
endmodule